// File: doc/BRIEF.md
# Programmable Synthesizer Divider and Phase Comparator

This block is the digital heart of a frequency synthesizer loop. A main divider counts edges of the prescaled RF signal. A reference divider counts edges of the crystal-derived signal. A phase/frequency comparator turns the relative timing of the two divider outputs into a source pulse (`up_o`) or a sink pulse (`dn_o`) for an external charge pump. Both incoming signals arrive as single-cycle edge strobes qualified by one fast fabric clock. All comparator timing is therefore measured in that clock's cycles.

The main ratio is a fixed base of 2176 plus a 7-bit coefficient. The coefficient bits are rotated before they are used. The reference ratio is one of four multiples of four. Starting and stopping are sequenced. On enable, both dividers leave a common zeroed state on the same cycle, so the loop never begins with an arbitrary phase error. On disable, a charge-pump pulse that is already open runs to its natural end before the dividers halt.

Top module: `pll_synth_core`

## Requirements
- R1: While reset is high, and after reset until the first enable, `up_o`, `dn_o`, `main_tc_o` and `ref_tc_o` are all low and both dividers rest at zero.
- R2: The main divider emits a one-cycle `main_tc_o` pulse once every N accepted `rf_tick` strobes. N = 2176 + k, where k = {coef_word[5:0], coef_word[6]}, so field bit 5 is the MSB of k and field bit 6 is its LSB. Cycles without `rf_tick` do not advance it.
- R3: The reference divider emits a one-cycle `ref_tc_o` pulse once every M accepted `xtal_tick` strobes, where ref_sel 00, 01, 10 and 11 give M = 4, 8, 12 and 16.
- R4: Enable is sampled at a clock edge. Counting begins at the next edge, with both dividers starting from zero. The first `main_tc_o` is seen in the cycle after the edge that accepts the Nth tick, and the first `ref_tc_o` in the cycle after the edge that accepts the Mth tick.
- R5: When `ref_tc_o` occurs before `main_tc_o`, `up_o` rises on the cycle after the reference pulse and falls on the cycle after the main pulse. It is therefore high for exactly the gap in cycles, while `dn_o` stays low.
- R6: When `main_tc_o` occurs first, `dn_o` is high for exactly the gap until `ref_tc_o`, and `up_o` stays low.
- R7: Terminal pulses that coincide produce neither output, and `up_o` and `dn_o` are never high together.
- R8: A new coefficient or reference select is picked up only at that divider's next terminal count. The period already running keeps its old length.
- R9: If enable drops while a pulse is open, that pulse ends at its normal terminating edge and no new pulse starts. The dividers then halt and emit no further terminal pulses until enabled again.
- R10: If enable drops while no pulse is open, neither output rises and the dividers halt within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that qualifies both tick strobes |
| rst | input | 1 | Synchronous active-high reset |
| rf_tick | input | 1 | One-cycle strobe per prescaled RF edge |
| xtal_tick | input | 1 | One-cycle strobe per crystal reference edge |
| synth_en | input | 1 | Synthesizer enable, sequenced start and stop |
| coef_word | input | 7 | Main coefficient field, rotated as in R2 |
| ref_sel | input | 2 | Reference ratio select |
| up_o | output | 1 | Source pulse request to the charge pump |
| dn_o | output | 1 | Sink pulse request to the charge pump |
| main_tc_o | output | 1 | Main divider terminal pulse |
| ref_tc_o | output | 1 | Reference divider terminal pulse |

## Verification
The two comparator inputs, the main and reference terminal pulses, can land in the same cycle. When they do, the set and clear paths of the comparator fire together. The bench provokes this by pacing the crystal strobe every 136 cycles with a reference ratio of 16, which exactly matches the main ratio of 2176. It judges the result by confirming that both terminal pulses appear in one cycle and that neither output ever rises. Neighbouring phase shifts and periods, on both sides of coincidence, check that the pulse width equals the arithmetically predicted gap.

// File: rtl/pll_syn_pkg.sv
package pll_syn_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic ref_ev;
    logic main_ev;
  } edge_pair_t;

endpackage

// File: rtl/pll_prog_div.sv
module pll_prog_div #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] ratio,
  output logic             tc
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             at_end;

  assign at_end = (cnt_q == lim_q);

  // Limit is captured only while halted or at a terminal count.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      lim_q <= ratio - CNT_W'(1);
      tc    <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (tick) begin
        if (at_end) begin
          cnt_q <= '0;
          lim_q <= ratio - CNT_W'(1);
          tc    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
  import pll_syn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       arm,
  input  edge_pair_t ev,
  output logic       up,
  output logic       dn
);

  logic up_nx;
  logic dn_nx;

  always_comb begin
    up_nx = up | ev.ref_ev;
    dn_nx = dn | ev.main_ev;
    if (up_nx && dn_nx) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end else if (!up && !dn && !arm) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_nx;
      dn <= dn_nx;
    end
  end

endmodule

// File: rtl/pll_seq.sv
module pll_seq
  import pll_syn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pulse_open,
  output logic run,
  output logic arm
);

  seq_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SEQ_IDLE;
    end else begin
      case (st_q)
        SEQ_IDLE:  if (en) st_q <= SEQ_RUN;
        SEQ_RUN:   if (!en) st_q <= pulse_open ? SEQ_DRAIN : SEQ_IDLE;
        SEQ_DRAIN: if (!pulse_open) st_q <= SEQ_IDLE;
        default:   st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign run = (st_q != SEQ_IDLE);
  assign arm = (st_q == SEQ_RUN) && en;

endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core #(
  parameter int MAIN_BASE = 2176,
  parameter int COEF_W    = 7,
  parameter int SEL_W     = 2,
  parameter int REF_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_tick,
  input  logic              xtal_tick,
  input  logic              synth_en,
  input  logic [COEF_W-1:0] coef_word,
  input  logic [SEL_W-1:0]  ref_sel,
  output logic              up_o,
  output logic              dn_o,
  output logic              main_tc_o,
  output logic              ref_tc_o
);
  import pll_syn_pkg::*;

  localparam int MAIN_W = $clog2(MAIN_BASE + (1 << COEF_W));
  localparam int REF_W  = $clog2(REF_STEP * (1 << SEL_W) + 1);

  logic [COEF_W-1:0] coef;
  logic [MAIN_W-1:0] main_ratio;
  logic [REF_W-1:0]  ref_ratio;
  logic              run;
  logic              arm;
  edge_pair_t        ev;

  // Field rotated: top field bit becomes the coefficient LSB.
  assign coef       = {coef_word[COEF_W-2:0], coef_word[COEF_W-1]};
  assign main_ratio = MAIN_W'(MAIN_BASE) + MAIN_W'(coef);
  assign ref_ratio  = REF_W'(REF_STEP) * (REF_W'(ref_sel) + REF_W'(1));

  pll_seq i_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (synth_en),
    .pulse_open (up_o | dn_o),
    .run        (run),
    .arm        (arm)
  );

  pll_prog_div #(.CNT_W(MAIN_W)) i_main_div (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .tick  (rf_tick),
    .ratio (main_ratio),
    .tc    (main_tc_o)
  );

  pll_prog_div #(.CNT_W(REF_W)) i_ref_div (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .tick  (xtal_tick),
    .ratio (ref_ratio),
    .tc    (ref_tc_o)
  );

  assign ev.ref_ev  = ref_tc_o;
  assign ev.main_ev = main_tc_o;

  pll_pfd i_pfd (
    .clk (clk),
    .rst (rst),
    .run (run),
    .arm (arm),
    .ev  (ev),
    .up  (up_o),
    .dn  (dn_o)
  );

endmodule

// File: rtl/pll_synth_core_chk.sv
module pll_synth_core_chk (
  input logic clk,
  input logic rst,
  input logic synth_en,
  input logic up_o,
  input logic dn_o,
  input logic main_tc_o,
  input logic ref_tc_o
);

  AST_UP_DN_EXCL: assert property (@(posedge clk) disable iff (rst) !(up_o && dn_o)); // R7
  AST_UP_SET_BY_REF: assert property (@(posedge clk) disable iff (rst) $rose(up_o) |-> $past(ref_tc_o)); // R5
  AST_UP_CLR_BY_MAIN: assert property (@(posedge clk) disable iff (rst) $fell(up_o) |-> $past(main_tc_o)); // R5
  AST_DN_SET_BY_MAIN: assert property (@(posedge clk) disable iff (rst) $rose(dn_o) |-> $past(main_tc_o)); // R6
  AST_DN_CLR_BY_REF: assert property (@(posedge clk) disable iff (rst) $fell(dn_o) |-> $past(ref_tc_o)); // R6
  AST_MAIN_TC_SINGLE: assert property (@(posedge clk) disable iff (rst) main_tc_o |=> !main_tc_o); // R2
  AST_REF_TC_SINGLE: assert property (@(posedge clk) disable iff (rst) ref_tc_o |=> !ref_tc_o); // R3
  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) (!synth_en && !up_o && !dn_o) |=> (!up_o && !dn_o)); // R10

endmodule

bind pll_synth_core pll_synth_core_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .synth_en  (synth_en),
  .up_o      (up_o),
  .dn_o      (dn_o),
  .main_tc_o (main_tc_o),
  .ref_tc_o  (ref_tc_o)
);

// File: tb/test_pll_synth_core.sv
module test_pll_synth_core;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2176;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rf_tick = 1'b0;
  logic       xtal_tick = 1'b0;
  logic       synth_en = 1'b0;
  logic [6:0] coef_word = '0;
  logic [1:0] ref_sel = '0;
  logic       up_o, dn_o, main_tc_o, ref_tc_o;

  int errors = 0;
  int checks = 0;
  int c = 0;
  int rf_div = 1;
  int xt_div = 1;
  int xt_sh = 0;
  bit done = 1'b0;

  pll_synth_core i_pll_synth_core (
    .clk(clk), .rst(rst), .rf_tick(rf_tick), .xtal_tick(xtal_tick),
    .synth_en(synth_en), .coef_word(coef_word), .ref_sel(ref_sel),
    .up_o(up_o), .dn_o(dn_o), .main_tc_o(main_tc_o), .ref_tc_o(ref_tc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int main_n(input logic [6:0] w);
    return BASE + ((int'(w[5:0]) << 1) | int'(w[6]));
  endfunction

  task automatic drive_ticks();
    rf_tick   = ((c % rf_div) == 0);
    xtal_tick = (((c + xt_sh) % xt_div) == 0);
  endtask

  task automatic step();
    @(negedge clk);
    c++;
    drive_ticks();
  endtask

  task automatic start();
    c = 0;
    synth_en = 1'b1;
    drive_ticks();
  endtask

  task automatic stop_wait();
    synth_en = 1'b0;
    for (int k = 0; k < 8000; k++) begin
      step();
      if (!up_o && !dn_o) break;
    end
    repeat (3) step();
  endtask

  task automatic wait_tc(input bit main_sel, input int limit, output int t);
    t = -1;
    for (int k = 0; k < limit; k++) begin
      step();
      if (main_sel ? main_tc_o : ref_tc_o) begin
        t = c;
        break;
      end
    end
  endtask

  task automatic run_first(output int t_ref, output int t_main, output int up_n, output int dn_n);
    int mx;
    start();
    t_ref = -1; t_main = -1; up_n = 0; dn_n = 0;
    for (int k = 0; k < 8000; k++) begin
      step();
      if (main_tc_o && t_main < 0) t_main = c;
      if (ref_tc_o && t_ref < 0) t_ref = c;
      up_n += int'(up_o);
      dn_n += int'(dn_o);
      mx = (t_ref > t_main) ? t_ref : t_main;
      if (t_ref >= 0 && t_main >= 0 && c >= mx + 1) break;
    end
  endtask

  initial begin
    int t1, t2, t3, tr, tm, un, dn, n, cnt;
    int wl[11] = '{0, 127, 1, 2, 4, 8, 16, 32, 64, 85, 42};
    int pl[5] = '{1, 200, 136, 136, 137};
    int sl[5] = '{0, 0, 0, 7, 0};
    int rl[5] = '{16, 16, 16, 16, 16};

    // R1: reset state and idle before enable
    repeat (3) @(negedge clk);
    check(!up_o && !dn_o && !main_tc_o && !ref_tc_o, "R1 outputs in reset", int'(up_o|dn_o|main_tc_o|ref_tc_o), 0);
    @(negedge clk);
    rst = 1'b0;
    rf_tick = 1'b1; xtal_tick = 1'b1;
    cnt = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cnt += int'(up_o | dn_o | main_tc_o | ref_tc_o);
    end
    check(cnt == 0, "R1 idle before enable", cnt, 0);

    // R2/R4: main ratio sweep with rotated coefficient
    ref_sel = 2'd0; xt_div = 1; xt_sh = 0; rf_div = 1;
    foreach (wl[i]) begin
      coef_word = 7'(wl[i]);
      n = main_n(coef_word);
      start();
      wait_tc(1'b1, 6000, t1);
      wait_tc(1'b1, 6000, t2);
      check(t1 == n + 1, "R4 first main pulse", t1, n + 1);
      check(t2 - t1 == n, "R2 main period", t2 - t1, n);
      stop_wait();
    end

    // R2: only accepted rf ticks advance the divider
    rf_div = 2; coef_word = 7'd3; n = main_n(7'd3);
    start();
    wait_tc(1'b1, 12000, t1);
    wait_tc(1'b1, 12000, t2);
    check(t2 - t1 == 2 * n, "R2 half-rate ticks", t2 - t1, 2 * n);
    stop_wait();
    rf_div = 1;

    // R3/R4: reference ratio for each select code
    coef_word = 7'd0;
    for (int s = 0; s < 4; s++) begin
      ref_sel = 2'(s);
      start();
      wait_tc(1'b0, 200, t1);
      wait_tc(1'b0, 200, t2);
      check(t1 == 4 * (s + 1) + 1, "R4 first ref pulse", t1, 4 * (s + 1) + 1);
      check(t2 - t1 == 4 * (s + 1), "R3 ref period", t2 - t1, 4 * (s + 1));
      stop_wait();
    end
    ref_sel = 2'd2; xt_div = 3;
    start();
    wait_tc(1'b0, 200, t1);
    wait_tc(1'b0, 200, t2);
    check(t2 - t1 == 36, "R3 sparse crystal ticks", t2 - t1, 36);
    stop_wait();
    xt_div = 1;

    // R8: coefficient change mid-period waits for terminal count
    coef_word = 7'd0; ref_sel = 2'd0;
    start();
    wait_tc(1'b1, 6000, t1);
    repeat (100) step();
    coef_word = 7'd127;
    wait_tc(1'b1, 6000, t2);
    wait_tc(1'b1, 6000, t3);
    check(t2 - t1 == main_n(7'd0), "R8 running period keeps old ratio", t2 - t1, main_n(7'd0));
    check(t3 - t2 == main_n(7'd127), "R8 new ratio at next period", t3 - t2, main_n(7'd127));
    stop_wait();

    // R5/R6/R7: phase comparator sweep over crystal pacing and shift
    ref_sel = 2'd3; rf_div = 1;
    for (int i = 0; i < 5; i++) begin
      int er, em, eu, ed;
      coef_word = (i == 0) ? 7'd5 : 7'd0;
      xt_div = pl[i]; xt_sh = sl[i];
      er = rl[i] * pl[i] - sl[i] + 1;
      em = main_n(coef_word) + 1;
      eu = (em > er) ? em - er : 0;
      ed = (er > em) ? er - em : 0;
      run_first(tr, tm, un, dn);
      check(tr == er, "R4 ref arrival", tr, er);
      check(tm == em, "R4 main arrival", tm, em);
      check(un == eu, (eu > 0) ? "R5 up width" : "R7 up quiet", un, eu);
      check(dn == ed, (ed > 0) ? "R6 dn width" : "R7 dn quiet", dn, ed);
      stop_wait();
    end
    xt_sh = 0;

    // R9: disable during an open up pulse
    xt_div = 1; ref_sel = 2'd3; coef_word = 7'd0;
    start();
    un = 0; dn = 0; t1 = 0; t2 = 0;
    for (int k = 0; k < 6000; k++) begin
      step();
      if (c == 1000) synth_en = 1'b0;
      un += int'(up_o);
      dn += int'(dn_o);
      if (main_tc_o) t1++;
      if (c >= 2180 && (main_tc_o || ref_tc_o)) t2++;
    end
    check(un == BASE - 16, "R9 open pulse completes", un, BASE - 16);
    check(dn == 0, "R9 no sink pulse", dn, 0);
    check(t1 == 1, "R9 single main pulse", t1, 1);
    check(t2 == 0, "R9 dividers halted", t2, 0);

    // R10: disable with nothing open
    xt_div = 200; coef_word = 7'd0;
    start();
    un = 0; t2 = 0;
    for (int k = 0; k < 5000; k++) begin
      step();
      if (c == 500) synth_en = 1'b0;
      un += int'(up_o | dn_o);
      if (c >= 503 && (main_tc_o || ref_tc_o)) t2++;
    end
    check(un == 0, "R10 no pulse", un, 0);
    check(t2 == 0, "R10 dividers halted", t2, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule